// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two W-bit operands and a carry-in. It does not let a carry ripple from bit to bit. Each bit first forms its own generate and propagate signals. A binary tree of combine cells merges them into generate/propagate pairs for ever larger groups. A second tree, shaped like the first, then sends carries from the root back down to every bit. Each carry is produced in a number of cell levels that grows with log2(W). The word-level generate and propagate also come out of the block, so that a wider adder can chain on them, and a carry-out is formed from them.

The arithmetic core is purely combinational. The sum, carry-out and word-level generate/propagate are captured in output registers, so every result appears one clock cycle after its operands are presented. A synchronous active-high reset clears those registers.

Top module: `cla_adder`

## Requirements
- R1: One cycle after operands `a`, `b` and `cin` are sampled on a rising edge, `sum` holds the low W bits of a + b + cin.
- R2: One cycle after sampling, `cout` holds bit W of a + b + cin, which is the carry out of the most significant position.
- R3: `grp_prop` is 1 exactly when every bit of (a xor b) is 1 for the sampled operands.
- R4: `grp_gen` is 1 exactly when a + b with zero carry-in overflows W bits for the sampled operands.
- R5: `grp_gen` and `grp_prop` are never 1 together.
- R6: `cout` equals `grp_gen` OR (`grp_prop` AND the sampled `cin`).
- R7: A rising edge with `rst` = 1 sets `sum`, `cout`, `grp_gen` and `grp_prop` to 0, whatever the operand inputs are.
- R8: When a xor b is all ones and cin = 1, the carry crosses the whole word: `sum` is 0 and `cout` is 1.
- R9: The width W is a parameter and must be a power of two of at least 2. Requirements R1 to R4 hold at W = 8 and at W = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and results registered on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Registered sum, low W bits |
| grp_gen | output | 1 | Registered generate of the whole word |
| grp_prop | output | 1 | Registered propagate of the whole word |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
The assertions assume that `a`, `b` and `cin` have known values at every rising edge outside reset. The arithmetic checks only count from the second edge after reset, which is the first edge whose output registers were loaded from real operands. The bench drives every input at the falling edge, so nothing is undefined when the design samples it. It changes `rst` only on falling edges and sets the operands before reset is released. Every value it applies comes from the exhaustive 8-bit walk, from a table of directed vectors, or from bounded random draws for the 32-bit instance. All of these are fully defined two-state values.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Flat index of the first node of tree level lvl in a W-leaf tree.
  // Level 0 holds the W bit cells, level log2(W) holds the root.
  function automatic int lvl_base(input int w, input int lvl);
    return 2 * w - 2 * (w >> lvl);
  endfunction
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_in,
  output logic g_o,
  output logic p_o,
  output logic s_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;
  // sum needs only propagate and incoming carry; no local carry-out
  assign s_o = p_o ^ c_in;
endmodule

// File: rtl/cla_gp_cell.sv
module cla_gp_cell (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi | (p_hi & g_lo);
  assign p_o = p_hi & p_lo;
endmodule

// File: rtl/cla_carry_cell.sv
module cla_carry_cell (
  input  logic c_in,
  input  logic g_lo,
  input  logic p_lo,
  output logic c_lo,
  output logic c_hi
);
  assign c_lo = c_in;
  assign c_hi = g_lo | (p_lo & c_in);
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grp_gen,
  output logic         grp_prop,
  output logic         cout
);
  localparam int LV    = $clog2(W);
  localparam int NODES = 2 * W - 1;
  localparam int ROOT  = NODES - 1;

  logic [NODES-1:0] g_n;
  logic [NODES-1:0] p_n;
  logic [NODES-1:0] c_n;
  logic [W-1:0]     sum_d;
  logic             cout_d;

  // leaf level: per-bit generate, propagate and sum
  for (genvar i = 0; i < W; i++) begin : g_bit
    cla_bit_cell u_bit (
      .a_i (a[i]),
      .b_i (b[i]),
      .c_in(c_n[i]),
      .g_o (g_n[i]),
      .p_o (p_n[i]),
      .s_o (sum_d[i])
    );
  end

  // upward GP tree and mirrored carry tree, one level per iteration
  for (genvar l = 1; l <= LV; l++) begin : g_lvl
    localparam int BASE  = cla_pkg::lvl_base(W, l);
    localparam int CBASE = cla_pkg::lvl_base(W, l - 1);
    for (genvar j = 0; j < (W >> l); j++) begin : g_node
      localparam int LO = CBASE + 2 * j;
      localparam int HI = CBASE + 2 * j + 1;
      cla_gp_cell u_gp (
        .g_hi(g_n[HI]),
        .p_hi(p_n[HI]),
        .g_lo(g_n[LO]),
        .p_lo(p_n[LO]),
        .g_o (g_n[BASE + j]),
        .p_o (p_n[BASE + j])
      );
      cla_carry_cell u_cy (
        .c_in(c_n[BASE + j]),
        .g_lo(g_n[LO]),
        .p_lo(p_n[LO]),
        .c_lo(c_n[LO]),
        .c_hi(c_n[HI])
      );
    end
  end

  assign c_n[ROOT] = cin;
  assign cout_d    = g_n[ROOT] | (p_n[ROOT] & cin);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum      <= '0;
      grp_gen  <= 1'b0;
      grp_prop <= 1'b0;
      cout     <= 1'b0;
    end else begin
      sum      <= sum_d;
      grp_gen  <= g_n[ROOT];
      grp_prop <= p_n[ROOT];
      cout     <= cout_d;
    end
  end

  // ---------------- assertions ----------------
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R1
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> sum == W'($past(a) + $past(b) + W'($past(cin))));

  // R2
  cout_match_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> cout == 1'(({1'b0, $past(a)} + {1'b0, $past(b)} + (W+1)'($past(cin))) >> W));

  // R3
  prop_word_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> grp_prop == (&($past(a) ^ $past(b))));

  // R5
  gen_prop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grp_gen && grp_prop));

  // R6
  cout_from_gp_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> cout == (grp_gen | (grp_prop & $past(cin))));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && !cout && !grp_gen && !grp_prop));
endmodule

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
  localparam int WS = 8;
  localparam int WL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WS-1:0] a8 = '0, b8 = '0;
  logic          c8 = 1'b0;
  logic [WS-1:0] s8;
  logic          g8, p8, co8;
  logic [WL-1:0] a32 = '0, b32 = '0;
  logic          c32 = 1'b0;
  logic [WL-1:0] s32;
  logic          g32, p32, co32;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cla_adder #(.W(WS)) u_cla_adder (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(c8),
    .sum(s8), .grp_gen(g8), .grp_prop(p8), .cout(co8)
  );

  cla_adder #(.W(WL)) u_cla_adder_w32 (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(c32),
    .sum(s32), .grp_gen(g32), .grp_prop(p32), .cout(co32)
  );

  // {a, b, cin, expected sum, expected cout}
  localparam logic [25:0] VEC [8] = '{
    {8'hff, 8'h01, 1'b0, 8'h00, 1'b1},
    {8'hff, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'h55, 8'haa, 1'b0, 8'hff, 1'b0},
    {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    {8'h7f, 8'h01, 1'b0, 8'h80, 1'b0},
    {8'h0f, 8'hf0, 1'b1, 8'h00, 1'b1},
    {8'ha5, 8'h5a, 1'b0, 8'hff, 1'b0}
  };

  // called one falling edge after operands were driven
  task automatic chk8(input logic [WS-1:0] a, input logic [WS-1:0] b, input logic ci);
    logic [WS:0] tot;
    logic        eg, ep;
    tot = {1'b0, a} + {1'b0, b} + (WS+1)'(ci);
    eg  = 1'(({1'b0, a} + {1'b0, b}) >> WS);
    ep  = &(a ^ b);
    tests++;
    if (s8 !== tot[WS-1:0] || co8 !== tot[WS]) begin
      fails++;
      $display("FAIL R1/R2 w8 a=%h b=%h ci=%b: sum=%h cout=%b expected sum=%h cout=%b",
               a, b, ci, s8, co8, tot[WS-1:0], tot[WS]);
    end else if (p8 !== ep || g8 !== eg) begin
      fails++;
      $display("FAIL R3/R4 w8 a=%h b=%h: gen=%b prop=%b expected gen=%b prop=%b",
               a, b, g8, p8, eg, ep);
    end else if (g8 && p8) begin
      fails++;
      $display("FAIL R5 w8 gen=%b prop=%b expected not both", g8, p8);
    end
  endtask

  task automatic chk32(input logic [WL-1:0] a, input logic [WL-1:0] b, input logic ci);
    logic [WL:0] tot;
    logic        eg, ep;
    tot = {1'b0, a} + {1'b0, b} + (WL+1)'(ci);
    eg  = 1'(({1'b0, a} + {1'b0, b}) >> WL);
    ep  = &(a ^ b);
    tests++;
    if (s32 !== tot[WL-1:0] || co32 !== tot[WL] || g32 !== eg || p32 !== ep) begin
      fails++;
      $display("FAIL R9 w32 a=%h b=%h ci=%b: sum=%h co=%b g=%b p=%b expected sum=%h co=%b g=%b p=%b",
               a, b, ci, s32, co32, g32, p32, tot[WL-1:0], tot[WL], eg, ep);
    end
  endtask

  task automatic chk_reset(input string tag);
    tests++;
    if (s8 !== '0 || co8 || g8 || p8 || s32 !== '0 || co32 || g32 || p32) begin
      fails++;
      $display("FAIL R7 %s: sum8=%h co8=%b g8=%b p8=%b sum32=%h expected all zero",
               tag, s8, co8, g8, p8, s32);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    // R7: reset holds outputs at zero even with live operands
    @(negedge clk);
    a8 = 8'hff; b8 = 8'hff; c8 = 1'b1;
    a32 = '1; b32 = '1; c32 = 1'b1;
    @(negedge clk);
    chk_reset("initial");
    rst = 1'b0;

    // directed table: R1, R2, R3, R4, R8 (all-propagate with cin=1)
    for (int v = 0; v < 8; v++) begin
      a8 = VEC[v][25:18]; b8 = VEC[v][17:10]; c8 = VEC[v][9];
      @(negedge clk);
      chk8(VEC[v][25:18], VEC[v][17:10], VEC[v][9]);
      tests++;
      if (s8 !== VEC[v][8:1] || co8 !== VEC[v][0]) begin
        fails++;
        $display("FAIL R8 vector %0d: sum=%h cout=%b expected sum=%h cout=%b",
                 v, s8, co8, VEC[v][8:1], VEC[v][0]);
      end
    end

    // R8 at 32 bits: full-word carry crossing
    a32 = 32'hffff_0000; b32 = 32'h0000_ffff; c32 = 1'b1;
    @(negedge clk);
    tests++;
    if (s32 !== '0 || co32 !== 1'b1) begin
      fails++;
      $display("FAIL R8 w32: sum=%h cout=%b expected sum=0 cout=1", s32, co32);
    end

    // exhaustive 8-bit walk (R1-R5) alongside random 32-bit traffic (R9)
    for (int k = 0; k < (1 << (2 * WS + 1)); k++) begin
      logic [WS-1:0] ta, tb;
      logic          tc;
      logic [WL-1:0] ra, rb;
      logic          rc;
      ta = k[WS-1:0]; tb = k[2*WS-1:WS]; tc = k[2*WS];
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      if ((k & 255) == 7) rb = ~ra;
      a8 = ta; b8 = tb; c8 = tc;
      a32 = ra; b32 = rb; c32 = rc;
      @(negedge clk);
      chk8(ta, tb, tc);
      if ((k & 15) == 0) chk32(ra, rb, rc);
    end

    // R7: reset in mid-run clears outputs
    a8 = 8'hc3; b8 = 8'h7e; c8 = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk_reset("mid-run");
    rst = 1'b0;
    @(negedge clk);
    chk8(8'hc3, 8'h7e, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule